// File: doc/BRIEF.md
# Maskable Fault Aggregation Status Unit

This unit gathers single-cycle fault events from a serial command port, a continuous-clock link, two FIFOs and the device core. Each event is held in a sticky detail flag. Per-source mask bits decide whether the four maskable sources also raise the global error flag. The unit publishes a 16-bit summary status word, three detail words and an active-low fault pin. The fault pin is always the inverse of the global error flag.

The unit also guards two commands against a busy link. A configuration write that arrives while the link is transmitting or receiving is refused. A soft reset that arrives while the link is transmitting is refused. Each refusal is recorded as a sticky flag in the status word. One write-1-to-clear command bit in the status word wipes every flag at once. This includes the power-on flag, which comes out of reset set.

Top module: `fault_agg_status`

## Requirements
- R1: `fault_no` always equals the inverse of status bit 0, which is the global error flag. Out of reset, `fault_no` is 0.
- R2: Maskable sources are `flt_i[0]` (command CRC), `flt_i[1]` (link input stuck), `flt_i[2]` (link CRC) and `flt_i[3]` (link check bit). `mask_i[k]` = 1 stops `flt_i[k]` from setting the global error flag.
- R3: Sources `flt_i[12:4]` always set the global error flag. Their meanings are: link command-queue overflow (4), command chip-select abort (5), command timeout (6), TX FIFO overflow (7), TX FIFO underflow (8), RX FIFO overflow (9), RX FIFO underflow (10), oscillator (11) and memory CRC (12).
- R4: After reset, the power-on flag (status bit 1) and the global error flag (status bit 0) are 1. Every other flag is 0, and all detail words are 0.
- R5: A cycle with `stat_we_i` = 1 and `stat_wd_i[15]` = 1 clears every flag on the next edge, so `fault_no` is high in the following cycle. A write with bit 15 = 0 changes nothing. Status bit 15 always reads 0.
- R6: A fault event in the same cycle as a clear-all wins. Its flags and the global error flag end up set.
- R7: Detail flags are sticky and set regardless of the mask. In `if_det_o`, bit 0 is stuck, bit 1 is link CRC, bit 3 is check bit, bit 4 is queue overflow, bit 8 is timeout and bit 9 is chip-select abort. `txf_det_o` and `rxf_det_o` carry overflow in bit 15 and underflow in bit 14.
- R8: Status word fields are:
  - bit 14: OR of the link detail flags
  - bit 12: OR of the TX FIFO detail flags
  - bit 11: OR of the RX FIFO detail flags
  - bit 8: OR of the chip-select and timeout flags
  - bit 6: command CRC
  - bit 3: memory CRC
  - bit 2: oscillator
  - bits 13, 5 and 4: always 0
- R9: When `cfg_wr_i` is 1 and either busy input is 1, `cfg_wr_ok_o` is 0 and status bit 7 sets. When both busy inputs are 0, the write passes (`cfg_wr_ok_o` = `cfg_wr_i`) and status bit 7 is unaffected.
- R10: When `srst_req_i` is 1 and `link_tx_busy_i` is 1, `srst_go_o` is 0 and status bit 9 sets. Receive-only activity does not block a soft reset.
- R11: Status bit 10 follows the current level of `drdy_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flt_i | input | 13 | Single-cycle fault events, one bit per source |
| mask_i | input | 4 | Mask bits for sources 0..3 |
| stat_we_i | input | 1 | Write strobe to the status word |
| stat_wd_i | input | 16 | Write data; bit 15 is the clear-all command |
| link_tx_busy_i | input | 1 | Link is transmitting |
| link_rx_busy_i | input | 1 | Link is receiving |
| cfg_wr_i | input | 1 | Configuration write attempt |
| srst_req_i | input | 1 | Soft reset request |
| drdy_i | input | 1 | Current data-ready pin level |
| cfg_wr_ok_o | output | 1 | Configuration write accepted |
| srst_go_o | output | 1 | Soft reset accepted |
| status_o | output | 16 | Summary status word |
| if_det_o | output | 16 | Interface detail word |
| txf_det_o | output | 16 | TX FIFO detail word |
| rxf_det_o | output | 16 | RX FIFO detail word |
| fault_no | output | 1 | Active-low fault pin |

## Verification
The bench focuses on three kinds of corner case.

- Masked faults. A design that masked the detail flag as well as the error flag would lose the detail bit. A design that ignored the mask would pull the pin low for a masked source.
- Clear-all in the same cycle as a new fault. A design with clear taking priority would drop the event and leave the pin high.
- Refusal conditions. A soft reset during receive-only activity must still pass, so a design that gated it on both busy inputs is caught. A configuration write during receive must be refused, so a design that looked only at transmit is caught.

The bench also checks that the power-on flag stays cleared once it is wiped, and that a status write without bit 15 leaves every flag untouched.

// File: rtl/fas_pkg.sv
package fas_pkg;
  localparam int unsigned N_SRC  = 13;
  localparam int unsigned N_MASK = 4;
  localparam int unsigned W      = 16;

  // source indices in flt_i
  localparam int unsigned S_CMD_CRC  = 0;
  localparam int unsigned S_LNK_STK  = 1;
  localparam int unsigned S_LNK_CRC  = 2;
  localparam int unsigned S_LNK_CHK  = 3;
  localparam int unsigned S_LNK_QOVF = 4;
  localparam int unsigned S_CMD_CS   = 5;
  localparam int unsigned S_CMD_TMO  = 6;
  localparam int unsigned S_TXF_OVF  = 7;
  localparam int unsigned S_TXF_UDF  = 8;
  localparam int unsigned S_RXF_OVF  = 9;
  localparam int unsigned S_RXF_UDF  = 10;
  localparam int unsigned S_OSC      = 11;
  localparam int unsigned S_MEM_CRC  = 12;

  // status word positions
  localparam int unsigned B_CLR   = 15;
  localparam int unsigned B_LNK   = 14;
  localparam int unsigned B_TXF   = 12;
  localparam int unsigned B_RXF   = 11;
  localparam int unsigned B_DRDY  = 10;
  localparam int unsigned B_SRST  = 9;
  localparam int unsigned B_CMD   = 8;
  localparam int unsigned B_WREF  = 7;
  localparam int unsigned B_CCRC  = 6;
  localparam int unsigned B_MCRC  = 3;
  localparam int unsigned B_OSC   = 2;
  localparam int unsigned B_POR   = 1;
  localparam int unsigned B_ERR   = 0;

  typedef struct packed {
    logic srst_ref;
    logic wr_ref;
  } refuse_t;
endpackage

// File: rtl/fas_sticky.sv
module fas_sticky #(
  parameter int unsigned WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_q, q_d;

  // set beats clear
  always_comb q_d = set_i | (q_q & ~{WIDTH{clr_i}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= RST_VAL;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((q_q & $past(q_q)) == $past(q_q))); // R7
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((q_q & $past(set_i)) == $past(set_i))); // R6
endmodule

// File: rtl/fas_gate.sv
module fas_gate (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_busy_i,
  input  logic              rx_busy_i,
  input  logic              cfg_wr_i,
  input  logic              srst_req_i,
  output logic              cfg_wr_ok_o,
  output logic              srst_go_o,
  output fas_pkg::refuse_t  ref_o
);
  logic link_busy;

  always_comb begin
    link_busy       = tx_busy_i | rx_busy_i;
    cfg_wr_ok_o     = cfg_wr_i & ~link_busy;
    srst_go_o       = srst_req_i & ~tx_busy_i;
    ref_o.wr_ref    = cfg_wr_i & link_busy;
    ref_o.srst_ref  = srst_req_i & tx_busy_i;
  end

  AST_WR_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && (tx_busy_i || rx_busy_i)) |-> !cfg_wr_ok_o); // R9
  AST_SRST_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srst_req_i && tx_busy_i) |-> !srst_go_o); // R10
  AST_SRST_RX_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srst_req_i && !tx_busy_i) |-> srst_go_o); // R10
endmodule

// File: rtl/fas_err.sv
module fas_err #(
  parameter int unsigned N_SRC  = fas_pkg::N_SRC,
  parameter int unsigned N_MASK = fas_pkg::N_MASK
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] flt_i,
  input  logic [N_MASK-1:0] mask_i,
  input  logic             clr_i,
  output logic             err_o,
  output logic             fault_no
);
  localparam int unsigned N_FIXED = N_SRC - N_MASK;

  logic [N_SRC-1:0] enable;
  logic             hit, err_q, err_d, pin_q;

  generate
    for (genvar k = 0; k < N_SRC; k++) begin : g_en
      if (k < N_MASK) begin : g_m
        assign enable[k] = ~mask_i[k];
      end else begin : g_f
        assign enable[k] = 1'b1;
      end
    end
  endgenerate

  always_comb begin
    hit   = |(flt_i & enable);
    err_d = hit | (err_q & ~clr_i);
  end

  // flag and pin kept in separate registers fed from one next-state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b1;
      pin_q <= 1'b0;
    end else begin
      err_q <= err_d;
      pin_q <= ~err_d;
    end
  end

  assign err_o    = err_q;
  assign fault_no = pin_q;

  AST_PIN_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_no == !err_o); // R1
  AST_UNMASKED_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(flt_i & {{N_FIXED{1'b1}}, ~mask_i})) |=> err_o); // R2
  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_o && ((flt_i & {{N_FIXED{1'b1}}, ~mask_i}) == '0)) |=> !err_o); // R2
  AST_CLR_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && ((flt_i & {{N_FIXED{1'b1}}, ~mask_i}) == '0)) |=> fault_no); // R5
endmodule

// File: rtl/fault_agg_status.sv
module fault_agg_status
  import fas_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  flt_i,
  input  logic [N_MASK-1:0] mask_i,
  input  logic              stat_we_i,
  input  logic [W-1:0]      stat_wd_i,
  input  logic              link_tx_busy_i,
  input  logic              link_rx_busy_i,
  input  logic              cfg_wr_i,
  input  logic              srst_req_i,
  input  logic              drdy_i,
  output logic              cfg_wr_ok_o,
  output logic              srst_go_o,
  output logic [W-1:0]      status_o,
  output logic [W-1:0]      if_det_o,
  output logic [W-1:0]      txf_det_o,
  output logic [W-1:0]      rxf_det_o,
  output logic              fault_no
);
  logic             clr_all;
  logic [N_SRC-1:0] det_q;
  refuse_t          ref_ev, ref_q;
  logic             por_q, err;

  assign clr_all = stat_we_i & stat_wd_i[B_CLR];

  fas_sticky #(.WIDTH(N_SRC), .RST_VAL('0)) u_det (
    .clk_i, .rst_ni, .set_i(flt_i), .clr_i(clr_all), .q_o(det_q)
  );

  fas_gate u_gate (
    .clk_i, .rst_ni,
    .tx_busy_i(link_tx_busy_i), .rx_busy_i(link_rx_busy_i),
    .cfg_wr_i, .srst_req_i,
    .cfg_wr_ok_o, .srst_go_o, .ref_o(ref_ev)
  );

  fas_sticky #(.WIDTH(2), .RST_VAL('0)) u_ref (
    .clk_i, .rst_ni, .set_i(ref_ev), .clr_i(clr_all), .q_o(ref_q)
  );

  fas_sticky #(.WIDTH(1), .RST_VAL(1'b1)) u_por (
    .clk_i, .rst_ni, .set_i(1'b0), .clr_i(clr_all), .q_o(por_q)
  );

  fas_err u_err (
    .clk_i, .rst_ni, .flt_i, .mask_i, .clr_i(clr_all),
    .err_o(err), .fault_no
  );

  always_comb begin
    if_det_o     = '0;
    if_det_o[0]  = det_q[S_LNK_STK];
    if_det_o[1]  = det_q[S_LNK_CRC];
    if_det_o[3]  = det_q[S_LNK_CHK];
    if_det_o[4]  = det_q[S_LNK_QOVF];
    if_det_o[8]  = det_q[S_CMD_TMO];
    if_det_o[9]  = det_q[S_CMD_CS];

    txf_det_o     = '0;
    txf_det_o[15] = det_q[S_TXF_OVF];
    txf_det_o[14] = det_q[S_TXF_UDF];
    rxf_det_o     = '0;
    rxf_det_o[15] = det_q[S_RXF_OVF];
    rxf_det_o[14] = det_q[S_RXF_UDF];

    status_o         = '0;
    status_o[B_LNK]  = |{if_det_o[4:3], if_det_o[1:0]};
    status_o[B_TXF]  = |txf_det_o[15:14];
    status_o[B_RXF]  = |rxf_det_o[15:14];
    status_o[B_DRDY] = drdy_i;
    status_o[B_SRST] = ref_q.srst_ref;
    status_o[B_CMD]  = |if_det_o[9:8];
    status_o[B_WREF] = ref_q.wr_ref;
    status_o[B_CCRC] = det_q[S_CMD_CRC];
    status_o[B_MCRC] = det_q[S_MEM_CRC];
    status_o[B_OSC]  = det_q[S_OSC];
    status_o[B_POR]  = por_q;
    status_o[B_ERR]  = err;
  end

  AST_CLR_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[B_CLR]); // R5
  AST_PIN_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_no == !status_o[B_ERR]); // R1
  AST_WR_REF_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && (link_tx_busy_i || link_rx_busy_i)) |=> status_o[B_WREF]); // R9
  AST_SRST_REF_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srst_req_i && link_tx_busy_i) |=> status_o[B_SRST]); // R10
  AST_POR_NO_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[B_POR] |=> !status_o[B_POR]); // R5
endmodule

// File: tb/tb_fault_agg_status.sv
`timescale 1ns/1ps
module tb_fault_agg_status;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [12:0] flt_i = '0;
  logic [3:0]  mask_i = '0;
  logic        stat_we_i = 1'b0;
  logic [15:0] stat_wd_i = '0;
  logic        link_tx_busy_i = 1'b0, link_rx_busy_i = 1'b0;
  logic        cfg_wr_i = 1'b0, srst_req_i = 1'b0, drdy_i = 1'b1;
  logic        cfg_wr_ok_o, srst_go_o, fault_no;
  logic [15:0] status_o, if_det_o, txf_det_o, rxf_det_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  fault_agg_status dut (
    .clk_i, .rst_ni, .flt_i, .mask_i, .stat_we_i, .stat_wd_i,
    .link_tx_busy_i, .link_rx_busy_i, .cfg_wr_i, .srst_req_i, .drdy_i,
    .cfg_wr_ok_o, .srst_go_o, .status_o, .if_det_o, .txf_det_o,
    .rxf_det_o, .fault_no
  );

  // {mask[3:0], flt[12:0], expected global error}
  localparam int NV = 10;
  localparam logic [17:0] VEC [0:NV-1] = '{
    {4'b0000, 13'h0001, 1'b1},
    {4'b0001, 13'h0001, 1'b0},
    {4'b1110, 13'h0004, 1'b0},
    {4'b1111, 13'h0080, 1'b1},
    {4'b1111, 13'h000F, 1'b0},
    {4'b0111, 13'h0008, 1'b1},
    {4'b0000, 13'h0000, 1'b0},
    {4'b0000, 13'h1000, 1'b1},
    {4'b1111, 13'h0020, 1'b1},
    {4'b0001, 13'h0002, 1'b1}
  };

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clear_all();
    @(negedge clk_i); stat_we_i = 1'b1; stat_wd_i = 16'h8000;
    @(posedge clk_i); #1 stat_we_i = 1'b0; stat_wd_i = '0;
  endtask

  task automatic pulse(logic [12:0] f, logic [3:0] m);
    @(negedge clk_i); flt_i = f; mask_i = m;
    @(posedge clk_i); #1 flt_i = '0;
  endtask

  function automatic logic [15:0] exp_stat(logic [12:0] f, logic e);
    logic [15:0] s = '0;
    s[14] = |f[4:1]; s[12] = |f[8:7]; s[11] = |f[10:9];
    s[10] = drdy_i;  s[8] = |f[6:5]; s[6] = f[0];
    s[3] = f[12];    s[2] = f[11];   s[0] = e;
    return s;
  endfunction

  function automatic logic [15:0] exp_if(logic [12:0] f);
    logic [15:0] s = '0;
    s[0] = f[1]; s[1] = f[2]; s[3] = f[3]; s[4] = f[4]; s[8] = f[6]; s[9] = f[5];
    return s;
  endfunction

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R4 reset state; R1 pin low; R11 drdy=1
    chk("R4 status", status_o, 16'h0403);
    chk("R4 if_det", if_det_o, 16'h0);
    chk("R4 fifo det", txf_det_o | rxf_det_o, 16'h0);
    chk("R1 pin at reset", {15'b0, fault_no}, 16'h0);

    // R5 write without bit 15 is ignored
    @(negedge clk_i); stat_we_i = 1'b1; stat_wd_i = 16'h7FFF;
    @(posedge clk_i); #1 stat_we_i = 1'b0;
    chk("R5 no-clear write", status_o, 16'h0403);

    // R5 clear-all, pin high next cycle, POR gone
    clear_all();
    chk("R5 cleared", status_o, 16'h0400);
    chk("R5 R1 pin high", {15'b0, fault_no}, 16'h1);

    // vector table: R2 R3 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic [12:0] f = VEC[i][13:1];
      logic [3:0]  m = VEC[i][17:14];
      logic        e = VEC[i][0];
      clear_all();
      pulse(f, m);
      chk($sformatf("R2 R3 R8 vec%0d status", i), status_o, exp_stat(f, e));
      chk($sformatf("R1 vec%0d pin", i), {15'b0, fault_no}, {15'b0, ~e});
      chk($sformatf("R7 vec%0d if_det", i), if_det_o, exp_if(f));
      chk($sformatf("R7 vec%0d txf", i), txf_det_o, {f[7], f[8], 14'b0});
      chk($sformatf("R7 vec%0d rxf", i), rxf_det_o, {f[9], f[10], 14'b0});
    end

    // R7 sticky after pulse gone, several idle cycles
    clear_all();
    pulse(13'h0600, 4'hF);
    repeat (3) @(posedge clk_i); #1;
    chk("R7 sticky rxf", rxf_det_o, 16'hC000);
    chk("R7 sticky err", {15'b0, status_o[0]}, 16'h1);

    // R6 fault in clear cycle wins
    clear_all();
    @(negedge clk_i); stat_we_i = 1'b1; stat_wd_i = 16'h8000; flt_i = 13'h0800; mask_i = 4'h0;
    @(posedge clk_i); #1 stat_we_i = 1'b0; flt_i = '0;
    chk("R6 set over clear", status_o, 16'h0405);
    chk("R6 pin low", {15'b0, fault_no}, 16'h0);

    // R9 refused write during receive
    clear_all();
    @(negedge clk_i); link_rx_busy_i = 1'b1; cfg_wr_i = 1'b1; #1;
    chk("R9 ok low when busy", {15'b0, cfg_wr_ok_o}, 16'h0);
    @(posedge clk_i); #1 cfg_wr_i = 1'b0; link_rx_busy_i = 1'b0;
    chk("R9 flag set", status_o, 16'h0480);
    clear_all();
    @(negedge clk_i); cfg_wr_i = 1'b1; #1;
    chk("R9 ok when idle", {15'b0, cfg_wr_ok_o}, 16'h1);
    @(posedge clk_i); #1 cfg_wr_i = 1'b0;
    chk("R9 no flag idle", status_o, 16'h0400);

    // R10 soft reset: rx-only passes, tx refuses
    @(negedge clk_i); link_rx_busy_i = 1'b1; srst_req_i = 1'b1; #1;
    chk("R10 go under rx", {15'b0, srst_go_o}, 16'h1);
    @(posedge clk_i); #1 link_rx_busy_i = 1'b0; srst_req_i = 1'b0;
    chk("R10 no flag rx", status_o, 16'h0400);
    @(negedge clk_i); link_tx_busy_i = 1'b1; srst_req_i = 1'b1; #1;
    chk("R10 blocked tx", {15'b0, srst_go_o}, 16'h0);
    @(posedge clk_i); #1 link_tx_busy_i = 1'b0; srst_req_i = 1'b0;
    chk("R10 flag set", status_o, 16'h0600);
    chk("R10 pin unaffected", {15'b0, fault_no}, 16'h1);

    // R11 drdy follows immediately
    @(negedge clk_i); drdy_i = 1'b0; #1;
    chk("R11 drdy low", {15'b0, status_o[10]}, 16'h0);
    @(negedge clk_i); drdy_i = 1'b1; #1;
    chk("R11 drdy high", {15'b0, status_o[10]}, 16'h1);

    // R5 POR never returns
    clear_all();
    repeat (2) @(posedge clk_i); #1;
    chk("R5 por stays low", status_o, 16'h0400);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule